// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Port

This block is the local-bus side of a pair of data FIFOs, clocked by a single bus clock. An inbound FIFO is filled by the host side and drained by local-bus reads. An outbound FIFO is filled by local-bus writes and drained by the host side. The host side is a plain push/pop port on each FIFO.

The local bus reaches the FIFOs in one of two ways. In register-style access, an address, active-low byte enables, an active-low select and active-low read/write strobes pick out the FIFO register. In direct access, two dedicated active-low enables bypass address decoding. Read data is presented as soon as a read access is enabled. Pointers move only on a rising clock edge that falls inside an enabled access.

The data bus leaves the block as a split output, enable and input triple, which the pad ring turns into the tri-state bus. A width-mode input narrows every transfer to 16 bits. In that mode a 32-bit entry moves as two half-words, the lower half first.

Top module: `fifo_port_sync`

## Requirements
- R1: While reset is asserted and after it is released, `rd_empty` and `out_empty` are 1, `wr_full` and `in_full` are 0, the three pulse outputs are 0 and `dq_oe` is 0.
- R2: A register read (`sel_n`=0, `rd_n`=0) is honoured only if `addr` equals `REG_ADDR` and the byte enables are valid. Valid means `be_n`=4'b0000 in 32-bit mode and `be_n[1:0]`=2'b00 in 16-bit mode. When honoured, `dq_out` shows the inbound head word in the same cycle, with no clock edge, and `dq_oe` is 2'b11. When not honoured, `dq_oe` stays 0.
- R3: Each rising edge during an enabled read of a non-empty FIFO advances the read pointer by one entry. The next word is then shown and stays stable until the following edge.
- R4: When a read access ends with no clock edge after the last word shown, the next read access shows that same word again.
- R5: `rd_empty`, `wr_full`, `in_full` and `out_empty` change only on a rising edge and show the FIFO state after that edge's pointer moves.
- R6: `dq_oe` is 0 whenever `sel_n` is high or `rd_n` is high, unless the direct read enable is active.
- R7: The direct read enable `drd_n` and the direct write enable `dwr_n` (both active low) perform reads and writes with `addr`, `be_n` and `sel_n` ignored.
- R8: If a direct enable is low while `rd_n` or `wr_n` is also low, `proto_err` pulses high for one cycle after that edge. The direct access is the one performed, and the FIFO moves by only one entry.
- R9: A read of an empty inbound FIFO, or a write to a full outbound FIFO, leaves the FIFO unchanged. It raises `underflow` or `overflow` respectively for one cycle after the edge.
- R10: With `half_mode`=1, each enabled edge moves one 16-bit half-word. Reads show bits 15:0 of the head entry, then bits 31:16, and the entry is popped after the upper half. `dq_oe`=2'b01, and `dq_out[31:16]` is 0. Writes capture `dq_in[15:0]` as the lower half and then as the upper half, and push only after the upper half.
- R11: A register write (`sel_n`=0, `wr_n`=0, address and byte enables valid) pushes `dq_in` into the outbound FIFO on the edge. The host side pops the words in write order from `host_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Register address for strobe access |
| be_n | input | 4 | Byte enables, active low |
| sel_n | input | 1 | Register select, active low |
| rd_n | input | 1 | Register read strobe, active low |
| wr_n | input | 1 | Register write strobe, active low |
| drd_n | input | 1 | Direct read enable, active low |
| dwr_n | input | 1 | Direct write enable, active low |
| half_mode | input | 1 | 1 selects 16-bit transfers |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data toward the bus |
| dq_oe | output | 2 | Output enables: bit 0 for lanes 15:0, bit 1 for lanes 31:16 |
| rd_empty | output | 1 | Inbound FIFO empty |
| wr_full | output | 1 | Outbound FIFO full |
| underflow | output | 1 | One-cycle pulse: read of an empty FIFO |
| overflow | output | 1 | One-cycle pulse: write to a full FIFO |
| proto_err | output | 1 | One-cycle pulse: strobe and direct enable low together |
| host_push | input | 1 | Host pushes `host_din` into the inbound FIFO |
| host_din | input | 32 | Host push data |
| in_full | output | 1 | Inbound FIFO full |
| host_pop | input | 1 | Host pops the outbound FIFO |
| host_dout | output | 32 | Outbound FIFO head word |
| out_empty | output | 1 | Outbound FIFO empty |

## Verification
Reads are tried with a wrong address, invalid byte enables and then a valid access. This separates the decode gate from the combinational data path. Burst reads are split by an idle cycle, which shows whether a dropped access re-presents its word rather than skipping it. A burst is also run to empty and then one past it, which shows that status flips on the right edge and that underflow leaves the pointer alone. Direct accesses use deliberately wrong address and byte-enable values. One of them is overlapped with a strobe, so that a double advance shows up as a skipped word. Half-word runs drive garbage on the upper data lanes and confirm the lower-then-upper order and pop timing in both directions.

// File: rtl/fifo_port_pkg.sv
package fifo_port_pkg;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic conflict;
    } access_t;

    typedef struct packed {
        logic        rd_half;
        logic        wr_half;
        logic [15:0] wr_lo;
        logic        underflow;
        logic        overflow;
        logic        proto_err;
    } port_state_t;

endpackage

// File: rtl/port_decode.sv
module port_decode
    import fifo_port_pkg::*;
#(
    parameter int              ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 5'h04
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              drd_n,
    input  logic              dwr_n,
    input  logic              half_mode,
    output access_t           acc
);

    logic be_ok;
    logic hit;
    logic direct;
    logic rd_req;
    logic wr_req;

    always_comb begin
        be_ok  = half_mode ? (be_n[1:0] == 2'b00) : (be_n == 4'b0000);
        hit    = !sel_n && (addr == REG_ADDR) && be_ok;
        direct = !drd_n || !dwr_n;
        // direct enables win over strobes; read wins over write
        rd_req = direct ? !drd_n : (hit && !rd_n);
        wr_req = direct ? !dwr_n : (hit && !wr_n);
        acc.rd_en    = rd_req;
        acc.wr_en    = wr_req && !rd_req;
        acc.conflict = direct && (!rd_n || !wr_n);
    end

endmodule

// File: rtl/sync_fifo.sv
module sync_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t        p_d, p_q;
    logic        do_push;
    logic        do_pop;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        empty   = (p_q.cnt == '0);
        full    = (p_q.cnt == CW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        p_d     = p_q;
        if (do_push) p_d.wp = (p_q.wp == AW'(DEPTH - 1)) ? '0 : p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = (p_q.rp == AW'(DEPTH - 1)) ? '0 : p_q.rp + 1'b1;
        p_d.cnt = p_q.cnt + CW'(do_push) - CW'(do_pop);
        head    = mem[p_q.rp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wp] <= din;
    end

    // R5: occupancy never exceeds the storage
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= CW'(DEPTH));

    // R3: a lone pop moves occupancy down by exactly one entry
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pop && !do_push) |=> (p_q.cnt == $past(p_q.cnt) - CW'(1)));

endmodule

// File: rtl/fifo_port_sync.sv
module fifo_port_sync
    import fifo_port_pkg::*;
#(
    parameter int                DEPTH    = 8,
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 5'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be_n,
    input  logic              sel_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              drd_n,
    input  logic              dwr_n,
    input  logic              half_mode,
    input  logic [31:0]       dq_in,
    output logic [31:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              rd_empty,
    output logic              wr_full,
    output logic              underflow,
    output logic              overflow,
    output logic              proto_err,
    input  logic              host_push,
    input  logic [31:0]       host_din,
    output logic              in_full,
    input  logic              host_pop,
    output logic [31:0]       host_dout,
    output logic              out_empty
);

    localparam int DW = 32;
    localparam int HW = DW / 2;

    access_t     acc;
    port_state_t s_d, s_q;
    logic          in_pop;
    logic          in_empty;
    logic [DW-1:0] in_head;
    logic          out_push;
    logic          out_full;
    logic [DW-1:0] out_din;

    port_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr(addr), .be_n(be_n), .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n),
        .drd_n(drd_n), .dwr_n(dwr_n), .half_mode(half_mode), .acc(acc)
    );

    sync_fifo #(.W(DW), .DEPTH(DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n), .push(host_push), .din(host_din),
        .pop(in_pop), .head(in_head), .empty(in_empty), .full(in_full)
    );

    sync_fifo #(.W(DW), .DEPTH(DEPTH)) u_out (
        .clk(clk), .rst_n(rst_n), .push(out_push), .din(out_din),
        .pop(host_pop), .head(host_dout), .empty(out_empty), .full(out_full)
    );

    always_comb begin
        s_d           = s_q;
        in_pop        = 1'b0;
        out_push      = 1'b0;
        out_din       = dq_in;
        s_d.underflow = acc.rd_en && in_empty;
        s_d.overflow  = acc.wr_en && out_full;
        s_d.proto_err = acc.conflict;

        if (acc.rd_en && !in_empty) begin
            if (half_mode && !s_q.rd_half) begin
                s_d.rd_half = 1'b1;
            end else begin
                in_pop      = 1'b1;
                s_d.rd_half = 1'b0;
            end
        end

        if (acc.wr_en && !out_full) begin
            if (half_mode && !s_q.wr_half) begin
                s_d.wr_lo   = dq_in[HW-1:0];
                s_d.wr_half = 1'b1;
            end else begin
                out_push    = 1'b1;
                if (half_mode) out_din = {dq_in[HW-1:0], s_q.wr_lo};
                s_d.wr_half = 1'b0;
            end
        end

        if (half_mode)
            dq_out = {{HW{1'b0}}, s_q.rd_half ? in_head[DW-1:HW] : in_head[HW-1:0]};
        else
            dq_out = in_head;
        dq_oe     = {acc.rd_en && !half_mode, acc.rd_en};
        rd_empty  = in_empty;
        wr_full   = out_full;
        underflow = s_q.underflow;
        overflow  = s_q.overflow;
        proto_err = s_q.proto_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: no drive without an enabled read path
    a_r6_float: assert property (@(posedge clk) disable iff (!rst_n)
        (drd_n && (sel_n || rd_n)) |-> (dq_oe == 2'b00));

    // R10: upper lanes never driven in 16-bit mode
    a_r10_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
        half_mode |-> !dq_oe[1]);

    // R10: an entry leaves only after its upper half was shown
    a_r10_pop_after_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop && half_mode) |-> s_q.rd_half);

    // R8: one edge never moves both FIFOs from the bus side
    a_r8_single_move: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_pop && out_push));

    // R9: an empty inbound FIFO stays empty without a host push
    a_r9_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (in_empty && !host_push) |=> rd_empty);

    // R9: a full outbound FIFO stays full without a host pop
    a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (out_full && !host_pop) |=> wr_full);

endmodule

// File: tb/sim_fifo_port_sync.sv
`timescale 1ns/1ps
module sim_fifo_port_sync;

    localparam int          DEPTH = 4;
    localparam logic [4:0]  RA    = 5'h04;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  addr;
    logic [3:0]  be_n;
    logic        sel_n, rd_n, wr_n, drd_n, dwr_n, half_mode;
    logic [31:0] dq_in, dq_out, host_din, host_dout;
    logic [1:0]  dq_oe;
    logic        rd_empty, wr_full, underflow, overflow, proto_err;
    logic        host_push, host_pop, in_full, out_empty;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    fifo_port_sync #(.DEPTH(DEPTH), .ADDR_W(5), .REG_ADDR(RA)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .be_n(be_n), .sel_n(sel_n),
        .rd_n(rd_n), .wr_n(wr_n), .drd_n(drd_n), .dwr_n(dwr_n),
        .half_mode(half_mode), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .rd_empty(rd_empty), .wr_full(wr_full), .underflow(underflow),
        .overflow(overflow), .proto_err(proto_err), .host_push(host_push),
        .host_din(host_din), .in_full(in_full), .host_pop(host_pop),
        .host_dout(host_dout), .out_empty(out_empty)
    );

    function automatic logic [31:0] word(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0003_0507;
    endfunction

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        sel_n = 1; rd_n = 1; wr_n = 1; drd_n = 1; dwr_n = 1;
        host_push = 0; host_pop = 0; addr = '0; be_n = 4'hf;
    endtask

    task automatic host_fill(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            host_push = 1; host_din = word(base + i);
            tick();
        end
        host_push = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        rst_n = 0; idle(); half_mode = 0; dq_in = '0; host_din = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rd_empty in reset", 32'(rd_empty), 32'd1);
        @(negedge clk); rst_n = 1; #1;
        chk("R1 rd_empty", 32'(rd_empty), 32'd1);
        chk("R1 out_empty", 32'(out_empty), 32'd1);
        chk("R1 full flags", {30'd0, wr_full, in_full}, 32'd0);
        chk("R1 pulses", {29'd0, underflow, overflow, proto_err}, 32'd0);
        chk("R1 dq_oe", 32'(dq_oe), 32'd0);

        // fill inbound, status after last edge
        host_fill(DEPTH, 0); #1;
        chk("R5 in_full after fill", 32'(in_full), 32'd1);
        chk("R5 rd_empty after fill", 32'(rd_empty), 32'd0);

        // decode gate
        sel_n = 0; rd_n = 0; be_n = 4'h0; addr = RA ^ 5'h01; #1;
        chk("R2 wrong address", 32'(dq_oe), 32'd0);
        addr = RA; be_n = 4'b0001; #1;
        chk("R2 bad byte enables", 32'(dq_oe), 32'd0);
        be_n = 4'h0; #1;
        chk("R2 oe", 32'(dq_oe), 32'd3);
        chk("R2 data before edge", dq_out, word(0));
        tick(); #1;
        chk("R3 advance", dq_out, word(1));
        rd_n = 1; #1;
        chk("R6 rd_n high floats", 32'(dq_oe), 32'd0);
        rd_n = 0; sel_n = 1; #1;
        chk("R6 sel_n high floats", 32'(dq_oe), 32'd0);
        sel_n = 1; rd_n = 1;
        tick();
        sel_n = 0; rd_n = 0; #1;
        chk("R4 same word again", dq_out, word(1));
        for (int i = 2; i < DEPTH; i++) begin
            tick(); #1;
            chk("R3 burst word", dq_out, word(i));
            chk("R5 not yet empty", 32'(rd_empty), 32'd0);
        end
        tick(); idle(); #1;
        chk("R5 empty after last pop", 32'(rd_empty), 32'd1);
        chk("R5 in_full cleared", 32'(in_full), 32'd0);

        // underflow
        sel_n = 0; rd_n = 0; addr = RA; be_n = 0;
        tick(); idle(); #1;
        chk("R9 underflow pulse", 32'(underflow), 32'd1);
        chk("R9 still empty", 32'(rd_empty), 32'd1);
        tick(); #1;
        chk("R9 underflow one cycle", 32'(underflow), 32'd0);

        // direct read ignoring address / byte enables
        host_fill(2, 10);
        drd_n = 0; addr = 5'h1f; be_n = 4'hf; #1;
        chk("R7 direct oe", 32'(dq_oe), 32'd3);
        chk("R7 direct data", dq_out, word(10));
        sel_n = 0; rd_n = 0; addr = RA; be_n = 0;
        tick(); idle(); #1;
        chk("R8 proto_err pulse", 32'(proto_err), 32'd1);
        drd_n = 0; #1;
        chk("R8 single advance", dq_out, word(11));
        tick(); idle(); #1;
        chk("R8 proto_err one cycle", 32'(proto_err), 32'd0);
        chk("R7 direct drained", 32'(rd_empty), 32'd1);

        // writes: register and direct mixed
        for (int i = 0; i < DEPTH; i++) begin
            dq_in = word(20 + i);
            if (i == 1) begin dwr_n = 0; addr = 5'h00; be_n = 4'hf; end
            else begin sel_n = 0; wr_n = 0; addr = RA; be_n = 0; end
            tick(); idle();
        end
        #1;
        chk("R5 wr_full", 32'(wr_full), 32'd1);
        sel_n = 0; wr_n = 0; addr = RA; be_n = 0; dq_in = word(99);
        tick(); idle(); #1;
        chk("R9 overflow pulse", 32'(overflow), 32'd1);
        for (int i = 0; i < DEPTH; i++) begin
            #1;
            chk("R11 write order", host_dout, word(20 + i));
            host_pop = 1; tick(); host_pop = 0;
        end
        #1;
        chk("R11 outbound drained", 32'(out_empty), 32'd1);
        chk("R9 overflow one cycle", 32'(overflow), 32'd0);

        // 16-bit mode
        half_mode = 1;
        host_fill(2, 30);
        drd_n = 0; #1;
        chk("R10 oe lower lanes only", 32'(dq_oe), 32'd1);
        for (int i = 0; i < 4; i++) begin
            #1;
            chk("R10 half order",
                dq_out, (i % 2 == 0) ? {16'h0, word(30 + i / 2)[15:0]}
                                     : {16'h0, word(30 + i / 2)[31:16]});
            chk("R10 pop after upper", 32'(rd_empty), 32'd0);
            tick();
        end
        idle(); #1;
        chk("R10 drained after four halves", 32'(rd_empty), 32'd1);
        sel_n = 0; rd_n = 0; addr = RA; be_n = 4'b1100; host_fill(1, 40); #1;
        chk("R2 half-mode byte enables", dq_out, {16'h0, word(40)[15:0]});
        tick(); tick(); idle();
        dwr_n = 0; dq_in = 32'hffff_1234;
        tick(); #1;
        chk("R10 no push after lower", 32'(out_empty), 32'd1);
        dq_in = 32'hffff_5678;
        tick(); idle(); #1;
        chk("R10 push after upper", 32'(out_empty), 32'd0);
        chk("R10 assembled word", host_dout, 32'h5678_1234);

        finish_run();
    end

endmodule